// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block sits beside a small processor core and arbitrates between two interrupt sources. The first is an active-low external pin, which is synchronised and watched for falling edges. The second is a single-cycle overflow pulse from a timer. Each source has a request flag and an enable bit. A global enable bit gates both sources. All of these live in one 8-bit control register that software can read and write.

When a source is ready to be served, the block offers the core a call request that carries a fixed vector address. The external source uses 0x04 and the timer uses 0x08. The call request is a valid/ready stream. The offer is a function of the current register state and the core's stack-full signal. It is not a buffered transfer, so `call_valid` may fall before it is taken if those conditions change. The core may hold `call_ready` low for as long as it likes, and nothing is consumed until a cycle in which both are high.

A taken call clears the served flag and the global enable, which blocks nesting. Software can still allow nesting by setting the global enable again inside the handler. The core reports its two return kinds. The return that re-enables interrupts restores the global enable, and the plain return leaves it alone. A wake request goes out whenever any enabled flag is pending.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the register reads 0x00, and `call_valid` and `wake_req` are both 0.
- R2: The register bit layout is: bit 0 global enable, bit 1 external enable, bit 2 timer enable, bit 4 external flag, bit 5 timer flag. Bits 3, 6 and 7 always read 0. A write replaces every implemented bit, so writing 1 to a flag sets it and writing 0 clears it.
- R3: A falling edge on `ext_irq_n` sets the external flag. The flag reads 1 after the third rising clock edge that follows the pin's fall: two synchroniser stages, then edge detection. A rising edge, or a pin that stays low, sets nothing.
- R4: A rising clock edge with `tmr_ovf` high sets the timer flag.
- R5: `call_valid` is 1 exactly when the global enable is 1, `stk_full` is 0, and at least one source has both its flag and its enable set.
- R6: `call_vector` is 0x04 when the external source is eligible and 0x08 when only the timer source is. When both are eligible, the external source wins and the timer flag stays set.
- R7: A clock edge with `call_valid` and `call_ready` both high clears the served source's flag and the global enable. With `call_ready` low, no state changes.
- R8: While the global enable is 0, source events still set their flags, but `call_valid` stays 0.
- R9: `reti_evt` sets the global enable. `ret_evt` leaves the global enable unchanged.
- R10: `wake_req` is 1 whenever any flag is set together with its enable, regardless of the global enable and `stk_full`.
- R11: When events coincide in one cycle, a hardware flag set beats a software write of 0 to that flag, and a taken call clears the global enable even if `reti_evt` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_n | input | 1 | External interrupt pin; a falling edge raises a request |
| tmr_ovf | input | 1 | Timer overflow pulse, one cycle per overflow |
| reg_wr_en | input | 1 | Software write strobe for the control register |
| reg_wr_data | input | 8 | Data written to the control register |
| reg_rd_data | output | 8 | Current control register contents |
| stk_full | input | 1 | Core return stack is full |
| ret_evt | input | 1 | Core executed a plain return |
| reti_evt | input | 1 | Core executed an interrupt return |
| call_valid | output | 1 | Call request offered |
| call_ready | input | 1 | Core accepts the call request this cycle |
| call_vector | output | 11 | Vector address of the offered call |
| wake_req | output | 1 | An enabled request is pending |

## Verification
The assertions take for granted that the core never raises `ret_evt` and `reti_evt` in the same cycle. They also take for granted that a software write does not coincide with a return event when the plain-return check is meant to apply, and that check is guarded against both cases. The stimulus keeps to these limits: every table row raises at most one return event. The one row that combines an interrupt return with a taken call is there on purpose, to exercise the precedence rule. The external pin is driven only at falling clock edges and held for several cycles, so every edge reaches the synchroniser cleanly.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int REG_W = 8;
  localparam int GIE_B = 0;
  localparam int EEN_B = 1;
  localparam int TEN_B = 2;
  localparam int EIF_B = 4;
  localparam int TIF_B = 5;

  typedef struct packed {
    logic tif;
    logic eif;
    logic ten;
    logic een;
    logic gie;
  } irq_state_t;

  function automatic logic [REG_W-1:0] pack_state(input irq_state_t s);
    logic [REG_W-1:0] r;
    r = '0;
    r[GIE_B] = s.gie;
    r[EEN_B] = s.een;
    r[TEN_B] = s.ten;
    r[EIF_B] = s.eif;
    r[TIF_B] = s.tif;
    return r;
  endfunction

  function automatic irq_state_t unpack_state(input logic [REG_W-1:0] r);
    irq_state_t s;
    s.gie = r[GIE_B];
    s.een = r[EEN_B];
    s.ten = r[TEN_B];
    s.eif = r[EIF_B];
    s.tif = r[TIF_B];
    return s;
  endfunction
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= sync_q[SYNC_STAGES-1];
  end

  assign fall_o = last_q & ~sync_q[SYNC_STAGES-1];

  // R3
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_vec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ext_set,
  input  logic             tmr_set,
  input  logic             ack_ext,
  input  logic             ack_tmr,
  input  logic             reti,
  output irq_state_t       state_o,
  output logic [REG_W-1:0] rd_data
);
  irq_state_t cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    if (wr_en)             nxt = unpack_state(wr_data);
    if (reti)              nxt.gie = 1'b1;
    if (ack_ext | ack_tmr) nxt.gie = 1'b0;
    if (ack_ext)           nxt.eif = 1'b0;
    if (ack_tmr)           nxt.tif = 1'b0;
    if (ext_set)           nxt.eif = 1'b1;
    if (tmr_set)           nxt.tif = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  assign state_o = cur_q;
  assign rd_data = pack_state(cur_q);

  // R7
  ack_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ext || ack_tmr) |=> !cur_q.gie);
  // R7
  ack_clears_eif_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ext && !ext_set) |=> !cur_q.eif);
  // R9
  reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack_ext && !ack_tmr) |=> cur_q.gie);
  // R4
  tmr_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_set |=> cur_q.tif);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vec_pkg::*;
#(
  parameter int              ADDR_W  = 11,
  parameter logic [ADDR_W-1:0] VEC_EXT = ADDR_W'(4),
  parameter logic [ADDR_W-1:0] VEC_TMR = ADDR_W'(8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irq_state_t        state_i,
  input  logic              stk_full,
  input  logic              call_ready,
  output logic              call_valid,
  output logic [ADDR_W-1:0] call_vector,
  output logic              ack_ext,
  output logic              ack_tmr,
  output logic              wake_req
);
  logic ext_ok, tmr_ok, take;

  assign ext_ok      = state_i.eif & state_i.een;
  assign tmr_ok      = state_i.tif & state_i.ten;
  assign wake_req    = ext_ok | tmr_ok;
  assign call_valid  = state_i.gie & ~stk_full & (ext_ok | tmr_ok);
  assign call_vector = ext_ok ? VEC_EXT : VEC_TMR;
  assign take        = call_valid & call_ready;
  assign ack_ext     = take & ext_ok;
  assign ack_tmr     = take & ~ext_ok & tmr_ok;

  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_ext, ack_tmr}));
  // R10
  valid_implies_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |-> wake_req);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_irq_n,
  input  logic              tmr_ovf,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_wr_data,
  output logic [7:0]        reg_rd_data,
  input  logic              stk_full,
  input  logic              ret_evt,
  input  logic              reti_evt,
  output logic              call_valid,
  input  logic              call_ready,
  output logic [ADDR_W-1:0] call_vector,
  output logic              wake_req
);
  logic       ext_fall, ack_ext, ack_tmr;
  irq_state_t st;

  irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_irq_n), .fall_o(ext_fall)
  );

  irq_ctl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .ext_set(ext_fall), .tmr_set(tmr_ovf), .ack_ext(ack_ext),
    .ack_tmr(ack_tmr), .reti(reti_evt), .state_o(st), .rd_data(reg_rd_data)
  );

  irq_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .state_i(st), .stk_full(stk_full),
    .call_ready(call_ready), .call_valid(call_valid),
    .call_vector(call_vector), .ack_ext(ack_ext), .ack_tmr(ack_tmr),
    .wake_req(wake_req)
  );

  // R9
  ret_keeps_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_evt && !reti_evt && !reg_wr_en && !(call_valid && call_ready))
      |=> (reg_rd_data[GIE_B] == $past(reg_rd_data[GIE_B])));
  // R5
  full_stack_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> !call_valid);
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_irq_n = 1'b1;
  logic        tmr_ovf = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_wr_data = '0;
  logic [7:0]  reg_rd_data;
  logic        stk_full = 1'b0;
  logic        ret_evt = 1'b0;
  logic        reti_evt = 1'b0;
  logic        call_valid;
  logic        call_ready = 1'b0;
  logic [10:0] call_vector;
  logic        wake_req;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .tmr_ovf(tmr_ovf),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .stk_full(stk_full), .ret_evt(ret_evt),
    .reti_evt(reti_evt), .call_valid(call_valid), .call_ready(call_ready),
    .call_vector(call_vector), .wake_req(wake_req)
  );

  // Row: {wr, wdata[8], tmr, stk, rdy, ret, reti, 2'b0,
  //       exp_rd[8], exp_valid, exp_wake, exp_vec[6]}
  localparam logic [31:0] TBL [NVEC] = '{
    {1'b1, 8'h07, 5'b00000, 2'b0, 8'h07, 1'b0, 1'b0, 6'h00}, // R2
    {1'b0, 8'h00, 5'b10000, 2'b0, 8'h27, 1'b1, 1'b1, 6'h08}, // R4 R5
    {1'b0, 8'h00, 5'b01000, 2'b0, 8'h27, 1'b0, 1'b1, 6'h00}, // R5 R10
    {1'b0, 8'h00, 5'b00100, 2'b0, 8'h06, 1'b0, 1'b0, 6'h00}, // R7
    {1'b0, 8'h00, 5'b10100, 2'b0, 8'h26, 1'b0, 1'b1, 6'h00}, // R8
    {1'b0, 8'h00, 5'b00010, 2'b0, 8'h26, 1'b0, 1'b1, 6'h00}, // R9
    {1'b0, 8'h00, 5'b00001, 2'b0, 8'h27, 1'b1, 1'b1, 6'h08}, // R9
    {1'b1, 8'h13, 5'b10000, 2'b0, 8'h33, 1'b1, 1'b1, 6'h04}, // R2
    {1'b1, 8'h37, 5'b00000, 2'b0, 8'h37, 1'b1, 1'b1, 6'h04}, // R6
    {1'b0, 8'h00, 5'b00100, 2'b0, 8'h26, 1'b0, 1'b1, 6'h00}, // R6 R7
    {1'b1, 8'h27, 5'b00000, 2'b0, 8'h27, 1'b1, 1'b1, 6'h08}, // R6
    {1'b0, 8'h00, 5'b00101, 2'b0, 8'h06, 1'b0, 1'b0, 6'h00}, // R11
    {1'b1, 8'hFF, 5'b00000, 2'b0, 8'h37, 1'b1, 1'b1, 6'h04}, // R2
    {1'b1, 8'h00, 5'b10000, 2'b0, 8'h20, 1'b0, 1'b0, 6'h00}, // R11 R10
    {1'b1, 8'h06, 5'b00000, 2'b0, 8'h06, 1'b0, 1'b0, 6'h00}  // R2
  };

  task automatic check(input string req, input logic [7:0] e_rd,
                       input logic e_v, input logic e_w,
                       input logic [5:0] e_vec);
    n_tests++;
    if (reg_rd_data !== e_rd || call_valid !== e_v || wake_req !== e_w ||
        (e_v && call_vector !== {5'b0, e_vec})) begin
      n_fail++;
      $display("FAIL %s: rd=%h valid=%b wake=%b vec=%h expected rd=%h valid=%b wake=%b vec=%h",
               req, reg_rd_data, call_valid, wake_req, call_vector,
               e_rd, e_v, e_w, e_vec);
    end
  endtask

  task automatic idle_inputs();
    reg_wr_en = 1'b0; reg_wr_data = '0; tmr_ovf = 1'b0; stk_full = 1'b0;
    call_ready = 1'b0; ret_evt = 1'b0; reti_evt = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 8'h00, 1'b0, 1'b0, 6'h00);
    rst_n = 1'b1;
    step();
    check("R1", 8'h00, 1'b0, 1'b0, 6'h00);

    for (int i = 0; i < NVEC; i++) begin
      reg_wr_en   = TBL[i][31];
      reg_wr_data = TBL[i][30:23];
      tmr_ovf     = TBL[i][22];
      stk_full    = TBL[i][21];
      call_ready  = TBL[i][20];
      ret_evt     = TBL[i][19];
      reti_evt    = TBL[i][18];
      step();
      check($sformatf("R2-table row %0d (R4/R5/R6/R7/R8/R9/R10/R11)", i),
            TBL[i][15:8], TBL[i][7], TBL[i][6], TBL[i][5:0]);
    end
    idle_inputs();

    // R3: pin edge path, flag after third edge
    reg_wr_en = 1'b1; reg_wr_data = 8'h03;
    step();
    idle_inputs();
    ext_irq_n = 1'b0;
    step();
    step();
    check("R3 not yet", 8'h03, 1'b0, 1'b0, 6'h00);
    step();
    check("R3 flag set", 8'h13, 1'b1, 1'b1, 6'h04);
    call_ready = 1'b1;
    step();
    call_ready = 1'b0;
    check("R7 ext taken", 8'h02, 1'b0, 1'b0, 6'h00);
    repeat (4) step();
    check("R3 held low", 8'h02, 1'b0, 1'b0, 6'h00);
    ext_irq_n = 1'b1;
    repeat (5) step();
    check("R3 rising ignored", 8'h02, 1'b0, 1'b0, 6'h00);

    // R8: edge while global enable clear sets flag, no call
    ext_irq_n = 1'b0;
    repeat (3) step();
    check("R8 flag no call", 8'h12, 1'b0, 1'b1, 6'h00);
    // R9: plain return keeps enable clear
    ret_evt = 1'b1;
    step();
    ret_evt = 1'b0;
    check("R9 ret no effect", 8'h12, 1'b0, 1'b1, 6'h00);
    // R5: nesting by software setting global enable
    reg_wr_en = 1'b1; reg_wr_data = 8'h13;
    step();
    reg_wr_en = 1'b0;
    check("R5 nest enable", 8'h13, 1'b1, 1'b1, 6'h04);
    // R7: back-pressure holds state
    repeat (3) step();
    check("R7 ready low", 8'h13, 1'b1, 1'b1, 6'h04);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule